// File: doc/BRIEF.md
# Cascaded Power-Good Output Sequencer

This block sequences a chain of active-low, open-drain power-good outputs once an external load switch is fully on. The first output goes active in the same cycle that the gate-fully-on flag and the drain-voltage-ok flag are both true and no supply fault is flagged. Each later output goes active a fixed number of clock edges after the stage before it. Each of these later stages also needs its own active-high enable.

Every output is presented as an open-drain pair: a pad data value and a pad output-enable. An asserted stage drives the pad low. A released stage turns its output-enable off, so the pad is high impedance and is never driven high. Releases are immediate. Losing the first-stage conditions, a fault, or a reset drops the whole chain in the same cycle. Pulling a stage enable low drops that stage and every stage after it. All affected delay counters restart from zero.

An enable pin that a board leaves unconnected reads as high. The parameter `EN_USED` models this by tying a stage's enable high and ignoring its pin.

Top module: `pg_cascade_seq`

## Requirements
- R1: `pg_oe_o[0]` is 1 in the same cycle (no clock edge needed) whenever `gate_on_i`=1, `drain_ok_i`=1, `fault_i`=0 and `rst`=0, and is 0 otherwise.
- R2: With `en_i[0]`=1, `pg_oe_o[1]` becomes 1 exactly `DELAY_CYCLES` rising clock edges after `pg_oe_o[0]` became 1, and stays 1 while both hold.
- R3: With `en_i[1]`=1, `pg_oe_o[2]` becomes 1 exactly `DELAY_CYCLES` rising clock edges after `pg_oe_o[1]` became 1.
- R4: `en_i[0]`=0 makes `pg_oe_o[1]` and `pg_oe_o[2]` 0 in the same cycle and leaves `pg_oe_o[0]` unchanged.
- R5: `en_i[1]`=0 makes `pg_oe_o[2]` 0 in the same cycle and leaves `pg_oe_o[1:0]` unchanged.
- R6: Open-drain pad pair: `pg_dat_o[k]` is 0 whenever `pg_oe_o[k]`=1, and is 1 while the pad is released. A stage is active exactly when its `pg_oe_o` bit is 1.
- R7: `fault_i`=1, or loss of either first-stage flag, releases all outputs in the same cycle. Once the conditions return, the full delays apply again: stage 1 after `DELAY_CYCLES` edges and stage 2 after 2*`DELAY_CYCLES` edges.
- R8: When an enable returns high after being low over at least one clock edge, and the preceding stage is already active, the stage waits the full `DELAY_CYCLES` edges before going active again.
- R9: While the synchronous active-high `rst` is 1, all `pg_oe_o` bits are 0. After `rst` falls, the chain restarts with cleared counters.
- R10: A stage whose `EN_USED` bit is 0 behaves as if its enable were high, and its `en_i` pin has no effect. This models an unconnected enable that defaults to enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gate_on_i | input | 1 | Load-switch gate is fully on |
| drain_ok_i | input | 1 | Drain voltage below the good threshold |
| fault_i | input | 1 | Undervoltage or overvoltage fault present |
| en_i | input | N_STAGES-1 | Stage enables; bit k-1 gates output k |
| pg_dat_o | output | N_STAGES | Pad data per output; 0 while driving |
| pg_oe_o | output | N_STAGES | Pad output-enable per output; 1 = driving low |

## Verification
The hardest situation to reach from the ports is a restart in the middle of the chain. This is an enable that returns while its predecessor is still active, and it must not inherit any partial count. The stimulus first brings the chain fully up. It then holds one enable low across at least one edge and raises it again. The bench counts edges from that moment against arithmetic expectations, once for each enable. A sweep over all four enable patterns and all eight first-stage flag combinations covers the rest. A second instance with both enables tied off runs alongside on grounded enable pins.

// File: rtl/pg_seq_pkg.sv
package pg_seq_pkg;

   // Counter width that can hold 0..delay, at least one bit.
   function automatic int cnt_width(input int delay);
      int w;
      w = 1;
      while ((1 << w) <= delay) w++;
      return w;
   endfunction

endpackage

// File: rtl/pg_stage_timer.sv
module pg_stage_timer #(
   parameter int DELAY_CYCLES = 6,
   parameter int CNT_W        = pg_seq_pkg::cnt_width(DELAY_CYCLES)
) (
   input  logic clk,
   input  logic rst,
   input  logic run_i,
   output logic done_o
);

   generate
      if (DELAY_CYCLES == 0) begin : g_nodelay
         assign done_o = 1'b1;
      end else begin : g_count
         localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DELAY_CYCLES);
         logic [CNT_W-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (rst || !run_i) begin
               cnt_q <= '0;
            end else if (cnt_q != LIMIT) begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign done_o = (cnt_q == LIMIT);
      end
   endgenerate

endmodule

// File: rtl/pg_en_mux.sv
module pg_en_mux #(
   parameter bit USED = 1'b1
) (
   input  logic en_i,
   output logic en_o
);

   generate
      if (USED) begin : g_pin
         assign en_o = en_i;
      end else begin : g_tied
         logic unused_pin;
         assign unused_pin = en_i;
         assign en_o = 1'b1;
      end
   endgenerate

endmodule

// File: rtl/pg_od_pad.sv
module pg_od_pad (
   input  logic assert_i,
   output logic dat_o,
   output logic oe_o
);

   assign oe_o  = assert_i;
   assign dat_o = ~assert_i;

endmodule

// File: rtl/pg_cascade_seq.sv
module pg_cascade_seq #(
   parameter int N_STAGES                = 3,
   parameter int DELAY_CYCLES            = 6,
   parameter logic [N_STAGES-2:0] EN_USED = '1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                gate_on_i,
   input  logic                drain_ok_i,
   input  logic                fault_i,
   input  logic [N_STAGES-2:0] en_i,
   output logic [N_STAGES-1:0] pg_dat_o,
   output logic [N_STAGES-1:0] pg_oe_o
);

   localparam int CNT_W = pg_seq_pkg::cnt_width(DELAY_CYCLES);
   localparam int N_EN  = N_STAGES - 1;

   generate
      if (N_STAGES < 2) begin : g_bad_stages
         $error("pg_cascade_seq: N_STAGES must be at least 2");
      end
      if (DELAY_CYCLES < 0) begin : g_bad_delay
         $error("pg_cascade_seq: DELAY_CYCLES must not be negative");
      end
   endgenerate

   logic [N_STAGES-1:0] drive;
   logic [N_EN-1:0]     en_eff;
   logic [N_EN-1:0]     run;
   logic [N_EN-1:0]     done;

   assign drive[0] = ~rst & gate_on_i & drain_ok_i & ~fault_i;

   genvar k;
   generate
      for (k = 1; k < N_STAGES; k++) begin : g_stage
         pg_en_mux #(.USED(EN_USED[k-1])) u_en (
            .en_i (en_i[k-1]),
            .en_o (en_eff[k-1])
         );

         assign run[k-1] = drive[k-1] & en_eff[k-1];

         pg_stage_timer #(
            .DELAY_CYCLES (DELAY_CYCLES),
            .CNT_W        (CNT_W)
         ) u_timer (
            .clk    (clk),
            .rst    (rst),
            .run_i  (run[k-1]),
            .done_o (done[k-1])
         );

         assign drive[k] = run[k-1] & done[k-1];
      end

      for (k = 0; k < N_STAGES; k++) begin : g_pad
         pg_od_pad u_pad (
            .assert_i (drive[k]),
            .dat_o    (pg_dat_o[k]),
            .oe_o     (pg_oe_o[k])
         );
      end
   endgenerate

endmodule

// File: rtl/pg_cascade_seq_chk.sv
module pg_cascade_seq_chk #(
   parameter int N_STAGES                = 3,
   parameter int DELAY_CYCLES            = 6,
   parameter logic [N_STAGES-2:0] EN_USED = '1
) (
   input logic                clk,
   input logic                rst,
   input logic                gate_on_i,
   input logic                drain_ok_i,
   input logic                fault_i,
   input logic [N_STAGES-2:0] en_i,
   input logic [N_STAGES-1:0] pg_dat_o,
   input logic [N_STAGES-1:0] pg_oe_o
);

   // R9
   reset_release_chk: assert property (@(posedge clk)
      rst |-> (pg_oe_o == '0));

   // R1
   first_on_chk: assert property (@(posedge clk) disable iff (rst)
      (gate_on_i && drain_ok_i && !fault_i) |-> pg_oe_o[0]);

   // R1
   first_off_chk: assert property (@(posedge clk) disable iff (rst)
      !(gate_on_i && drain_ok_i && !fault_i) |-> !pg_oe_o[0]);

   // R7
   fault_release_chk: assert property (@(posedge clk) disable iff (rst)
      fault_i |-> (pg_oe_o == '0));

   genvar k;
   generate
      for (k = 0; k < N_STAGES; k++) begin : g_pad_chk
         // R6
         od_never_high_chk: assert property (@(posedge clk) disable iff (rst)
            pg_oe_o[k] |-> !pg_dat_o[k]);
      end

      for (k = 1; k < N_STAGES; k++) begin : g_chain_chk
         // R2 R3
         chain_order_chk: assert property (@(posedge clk) disable iff (rst)
            pg_oe_o[k] |-> pg_oe_o[k-1]);

         if (DELAY_CYCLES > 0) begin : g_delayed
            // R2 R3
            rise_after_pred_chk: assert property (@(posedge clk) disable iff (rst)
               $rose(pg_oe_o[k]) |-> $past(pg_oe_o[k-1]));
         end

         if (EN_USED[k-1]) begin : g_en
            // R4 R5
            enable_drop_chk: assert property (@(posedge clk) disable iff (rst)
               !en_i[k-1] |-> !pg_oe_o[k]);
         end
      end
   endgenerate

endmodule

bind pg_cascade_seq pg_cascade_seq_chk #(
   .N_STAGES     (N_STAGES),
   .DELAY_CYCLES (DELAY_CYCLES),
   .EN_USED      (EN_USED)
) u_chk (
   .clk        (clk),
   .rst        (rst),
   .gate_on_i  (gate_on_i),
   .drain_ok_i (drain_ok_i),
   .fault_i    (fault_i),
   .en_i       (en_i),
   .pg_dat_o   (pg_dat_o),
   .pg_oe_o    (pg_oe_o)
);

// File: tb/pg_cascade_seq_bench.sv
`timescale 1ns/1ps
module pg_cascade_seq_bench;

   localparam int D = 6;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       gate_on = 1'b1;
   logic       drain_ok = 1'b1;
   logic       fault = 1'b0;
   logic [1:0] en = 2'b11;
   logic [1:0] en_t = 2'b00;
   logic [2:0] dat, oe, dat_t, oe_t;

   int  checks = 0;
   int  errors = 0;
   bit  finished = 1'b0;

   always #4 clk = ~clk;

   pg_cascade_seq #(.N_STAGES(3), .DELAY_CYCLES(D), .EN_USED(2'b11)) u_pg_cascade_seq (
      .clk(clk), .rst(rst), .gate_on_i(gate_on), .drain_ok_i(drain_ok),
      .fault_i(fault), .en_i(en), .pg_dat_o(dat), .pg_oe_o(oe));

   pg_cascade_seq #(.N_STAGES(3), .DELAY_CYCLES(D), .EN_USED(2'b00)) u_pg_cascade_seq_tied (
      .clk(clk), .rst(rst), .gate_on_i(gate_on), .drain_ok_i(drain_ok),
      .fault_i(fault), .en_i(en_t), .pg_dat_o(dat_t), .pg_oe_o(oe_t));

   task automatic chk(input logic [2:0] exp, input string tag);
      checks++;
      if (oe !== exp || dat !== ~exp) begin
         errors++;
         $display("FAIL %s: oe=%b dat=%b expected oe=%b dat=%b", tag, oe, dat, exp, ~exp);
      end
   endtask

   task automatic chk_t(input logic [2:0] exp, input string tag);
      checks++;
      if (oe_t !== exp || dat_t !== ~exp) begin
         errors++;
         $display("FAIL %s (tied): oe=%b dat=%b expected oe=%b dat=%b", tag, oe_t, dat_t, exp, ~exp);
      end
   endtask

   // Edge-by-edge ramp; j counts rising edges since the stimulus at the last negedge.
   task automatic ramp(input logic [1:0] e, input int s1, input int s2,
                       input bit tfresh, input string tag);
      logic [2:0] exp, exp_t;
      for (int j = 1; j <= 3 * D; j++) begin
         @(posedge clk); #1;
         exp[0] = 1'b1;
         exp[1] = e[0] && (j >= s1);
         exp[2] = e[0] && e[1] && (j >= s2);
         exp_t  = tfresh ? {(j >= 2 * D), (j >= D), 1'b1} : 3'b111;
         chk(exp, tag);
         chk_t(exp_t, {tag, " R10"});
      end
   endtask

   initial begin
      // R9: held in reset with good conditions present
      repeat (3) @(posedge clk);
      #1;
      chk(3'b000, "R9 reset holds outputs");
      chk_t(3'b000, "R9 reset holds outputs");

      @(negedge clk); rst = 1'b0; #1;
      chk(3'b001, "R1 first stage immediate");
      ramp(2'b11, D, 2 * D, 1'b1, "R2 R3 cascade after reset");

      // Sweep all enable patterns from a fresh start
      for (int e = 0; e < 4; e++) begin
         @(negedge clk); gate_on = 1'b0; #1;
         chk(3'b000, "R7 gate loss releases all");
         chk_t(3'b000, "R7 gate loss releases all");
         @(negedge clk); en = e[1:0]; gate_on = 1'b1; #1;
         chk(3'b001, "R1 first stage on");
         ramp(e[1:0], D, 2 * D, 1'b1, "R2 R3 enable sweep");
      end

      // R4 + R8: enable A drop and return
      @(negedge clk); en[0] = 1'b0; #1;
      chk(3'b001, "R4 enable A drop");
      @(posedge clk); #1;
      chk(3'b001, "R4 enable A held low");
      @(negedge clk); en[0] = 1'b1; #1;
      chk(3'b001, "R8 enable A return");
      ramp(2'b11, D, 2 * D, 1'b0, "R8 restart after enable A");

      // R5 + R8: enable B drop and return
      @(negedge clk); en[1] = 1'b0; #1;
      chk(3'b011, "R5 enable B drop");
      @(posedge clk); #1;
      chk(3'b011, "R5 enable B held low");
      @(negedge clk); en[1] = 1'b1; #1;
      chk(3'b011, "R8 enable B return");
      ramp(2'b11, 0, D, 1'b0, "R8 restart after enable B");

      // R7: fault
      @(negedge clk); fault = 1'b1; #1;
      chk(3'b000, "R7 fault releases all");
      chk_t(3'b000, "R7 fault releases all");
      @(posedge clk); #1;
      chk(3'b000, "R7 fault held");
      @(negedge clk); fault = 1'b0; #1;
      chk(3'b001, "R7 fault cleared");
      ramp(2'b11, D, 2 * D, 1'b1, "R7 full delays after fault");

      // R9: reset in mid-run
      @(negedge clk); rst = 1'b1; #1;
      chk(3'b000, "R9 reset mid-run");
      chk_t(3'b000, "R9 reset mid-run");
      @(posedge clk); #1;
      chk(3'b000, "R9 reset held");
      @(negedge clk); rst = 1'b0; #1;
      chk(3'b001, "R9 release after reset");
      ramp(2'b11, D, 2 * D, 1'b1, "R9 restart after reset");

      // R1/R6: all first-stage flag combinations, later stages disabled
      en = 2'b00;
      for (int c = 0; c < 8; c++) begin
         @(negedge clk);
         gate_on = c[0]; drain_ok = c[1]; fault = c[2];
         #1;
         chk({2'b00, (c[0] & c[1] & ~c[2])}, "R1 R6 flag sweep");
         @(posedge clk); #1;
         chk({2'b00, (c[0] & c[1] & ~c[2])}, "R1 R6 flag sweep after edge");
      end

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!finished) begin
         errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule